// File: doc/BRIEF.md
# Six-Bit NOR Processor Core

A small multi-cycle processor with a 6-bit datapath and a 12-bit address space of 4096 six-bit words. It holds three general registers (A, B, C) and a program counter, and executes four primary operations: NOR into a register, jump, load into C and store from C. NOR is the only logic operation. Rotates are done by reading from two read-only lookup pages that the core answers by itself. An immediate operand is supplied by placing its value in the instruction stream right after the instruction word.

The core drives one synchronous memory port. Every cycle it presents an address, and the external RAM returns that word on `mem_rdata` during the next cycle. Reads that fall outside the RAM window are answered internally: two words that expose the program counter, the two rotate pages, and reserved space that reads as zero. Stores outside the RAM window never raise the write strobe. A halt instruction parks the core until the interrupt line is seen high. Execution then continues with the next instruction, and there is no vectoring.

Top module: `nor6_core`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the PC and A, B, C are zero: `mem_addr` is 0x000, `mem_we` is 0 and `mem_wdata` is 0.
- R2: Every instruction starts with a fetch cycle (address = PC), then a decode cycle (address = PC+1). Each immediate word then adds one cycle, and an execute cycle follows. LOAD adds one more cycle after execute. The PC steps by one for every word consumed, including immediate words, and the Y immediate is consumed before the Z immediate. In every cycle other than a LOAD or STORE execute, `mem_addr` shows the current PC.
- R3: Instruction word bits [5:4] are the opcode (00 NOR, 01 jump, 10 LOAD, 11 STORE), bits [3:2] are operand Y and bits [1:0] are operand Z. An operand code of 00 selects A, 01 selects B, 10 selects C, and 11 takes the next stream word as the value.
- R4: NOR writes the bitwise NOR of the Y and Z values into the register named by Y.
- R5: Word 001100 is a no-op, and 001101 and 001110 also act as no-ops. None of the 0011xx words consumes an immediate word.
- R6: Jump loads the PC with {Y value, Z value}, Y being the upper six bits, after the instruction's immediate words are consumed.
- R7: STORE drives `mem_we` high for its execute cycle, with `mem_addr` = {Y,Z} and `mem_wdata` = C, when that address is below 0xF00.
- R8: A STORE to any address from 0xF00 upward leaves `mem_we` low, and memory is unchanged.
- R9: A LOAD from 0xF3E returns the upper six bits of the PC as it stands at the LOAD's execute cycle (the address of the next instruction). A LOAD from 0xF3F returns the lower six bits.
- R10: A LOAD from 0xF80+v returns v rotated left by one bit. A LOAD from 0xFC0+v returns v rotated right by one bit.
- R11: A LOAD from the reserved ranges 0xF00–0xF3D and 0xF40–0xF7F returns zero.
- R12: Word 001111 halts the core. While halted, `mem_addr` holds the address after the halt word and `mem_we` stays low. The first cycle in which `irq` is high while halted is the last halted cycle, and the fetch of the next word follows it.
- R13: `irq` has no effect while the core is not halted.
- R14: A LOAD below 0xF00 places into C the `mem_rdata` word returned one cycle after the address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt; ends a halt |
| mem_addr | output | 12 | Memory address, presented every cycle |
| mem_we | output | 1 | Write strobe for the RAM window |
| mem_wdata | output | 6 | Write data (register C) |
| mem_rdata | input | 6 | RAM read data, one cycle after its address |

## Verification
The hardest situation to reach is a program counter read made through the read-only words after an instruction that consumed immediates. The expected value then depends on how many stream words were counted before execute. The stimulus reaches it with two-immediate LOADs of those words, first at a low address and again after jumps into a higher page, so both halves are non-trivial. A second awkward case is a wake-up from halt. The bench drives `irq` high both during normal execution, where it must change nothing, and at one chosen cycle inside a halt. The cycle-exact model then sets exactly when the next fetch address must appear.

// File: rtl/nor6_core.sv
module nor6_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq,
  output logic [11:0] mem_addr,
  output logic        mem_we,
  output logic [5:0]  mem_wdata,
  input  logic [5:0]  mem_rdata
);
  localparam int DW = 6;
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] RAM_LIMIT  = AW'(12'hF00);
  localparam logic [AW-1:0] PC_HI_ADDR = AW'(12'hF3E);
  localparam logic [AW-1:0] PC_LO_ADDR = AW'(12'hF3F);
  localparam logic [DW-1:0] ROL_PAGE   = DW'(6'h3E);
  localparam logic [DW-1:0] ROR_PAGE   = DW'(6'h3F);
  localparam logic [1:0] OP_NOR = 2'b00;
  localparam logic [1:0] OP_JMP = 2'b01;
  localparam logic [1:0] OP_LD  = 2'b10;
  localparam logic [1:0] OP_ST  = 2'b11;
  localparam logic [1:0] SEL_IMM = 2'b11;

  typedef enum logic [2:0] {
    S_FETCH, S_DEC, S_IMMY, S_IMMZ, S_EXEC, S_LDW, S_HALT
  } state_t;

  state_t         st;
  logic [AW-1:0]  pc, rd_addr, rd_pc, ea;
  logic [DW-1:0]  ra, rb, rc, ir, yimm, zimm;
  logic [DW-1:0]  rdat, word, yreg, zreg, yval, zval, nor_res;
  logic [1:0]     op, fy, fz;
  logic           special;

  // read data routing by the address presented in the previous cycle
  always_comb begin
    rdat = '0;
    if (rd_addr < RAM_LIMIT)                  rdat = mem_rdata;
    else if (rd_addr == PC_HI_ADDR)           rdat = rd_pc[AW-1:DW];
    else if (rd_addr == PC_LO_ADDR)           rdat = rd_pc[DW-1:0];
    else if (rd_addr[AW-1:DW] == ROL_PAGE)    rdat = {rd_addr[DW-2:0], rd_addr[DW-1]};
    else if (rd_addr[AW-1:DW] == ROR_PAGE)    rdat = {rd_addr[0], rd_addr[DW-1:1]};
  end

  assign word    = (st == S_DEC) ? rdat : ir;
  assign op      = word[5:4];
  assign fy      = word[3:2];
  assign fz      = word[1:0];
  assign special = (op == OP_NOR) && (fy == SEL_IMM);

  always_comb begin
    case (fy)
      2'b00:   yreg = ra;
      2'b01:   yreg = rb;
      default: yreg = rc;
    endcase
    case (fz)
      2'b00:   zreg = ra;
      2'b01:   zreg = rb;
      default: zreg = rc;
    endcase
  end

  assign yval    = (fy == SEL_IMM) ? yimm : yreg;
  assign zval    = (fz == SEL_IMM) ? zimm : zreg;
  assign ea      = {yval, zval};
  assign nor_res = ~(yval | zval);

  assign mem_addr  = (st == S_EXEC && op[1]) ? ea : pc;
  assign mem_we    = (st == S_EXEC) && (op == OP_ST) && (ea < RAM_LIMIT);
  assign mem_wdata = rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FETCH;
      pc      <= '0;
      ra      <= '0;
      rb      <= '0;
      rc      <= '0;
      ir      <= '0;
      yimm    <= '0;
      zimm    <= '0;
      rd_addr <= '0;
      rd_pc   <= '0;
    end else begin
      rd_addr <= mem_addr;
      rd_pc   <= pc;
      case (st)
        S_FETCH: begin
          pc <= pc + 1'b1;
          st <= S_DEC;
        end
        S_DEC: begin
          ir <= rdat;
          if (special) st <= S_EXEC;
          else if (fy == SEL_IMM) begin
            pc <= pc + 1'b1;
            st <= S_IMMY;
          end else if (fz == SEL_IMM) begin
            pc <= pc + 1'b1;
            st <= S_IMMZ;
          end else st <= S_EXEC;
        end
        S_IMMY: begin
          yimm <= rdat;
          if (fz == SEL_IMM) begin
            pc <= pc + 1'b1;
            st <= S_IMMZ;
          end else st <= S_EXEC;
        end
        S_IMMZ: begin
          zimm <= rdat;
          st   <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_FETCH;
          case (op)
            OP_NOR: begin
              if (special) begin
                if (fz == 2'b11) st <= S_HALT;
              end else begin
                case (fy)
                  2'b00:   ra <= nor_res;
                  2'b01:   rb <= nor_res;
                  default: rc <= nor_res;
                endcase
              end
            end
            OP_JMP:  pc <= ea;
            OP_LD:   st <= S_LDW;
            default: ;
          endcase
        end
        S_LDW: begin
          rc <= rdat;
          st <= S_FETCH;
        end
        S_HALT: if (irq) st <= S_FETCH;
        default: st <= S_FETCH;
      endcase
    end
  end

  a_r2_pc_step_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |=> (pc == $past(pc) + 12'd1));

  a_r5_no_imm_for_special: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && special) |=> (st == S_EXEC));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC && op == OP_JMP) |=> (pc == $past(ea)));

  a_r14_load_lands_in_c: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LDW) |=> (rc == $past(rdat)));

  a_r8_no_write_above_ram: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr < RAM_LIMIT));

  a_r12_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT && !irq) |=> (st == S_HALT && pc == $past(pc) && !mem_we));
endmodule

// File: tb/nor6_core_test.sv
module nor6_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [5:0]  mem_wdata;
  logic [5:0]  mem_rdata = 6'd0;
  logic [5:0]  ram [0:4095];

  int    mm [0:4095];
  int    qa[$], qw[$], qd[$], qi[$];
  string qt[$];
  int    checks = 0, errors = 0;
  int    m_pc = 0, m_a = 0, m_b = 0, m_c = 0;
  int    lp = 0;
  bit    done = 0;

  always #2 clk = ~clk;

  nor6_core uut (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string tg, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tg, what, got, exp, $time);
    end
  endtask

  task automatic put(input int a, input int w);
    mm[a] = w;
    ram[a] <= w[5:0];
  endtask

  task automatic e(input int w);
    put(lp, w);
    lp++;
  endtask

  function automatic int ins(input int op, input int y, input int z);
    return op * 16 + y * 4 + z;
  endfunction

  function automatic int rd(input int a, input int p);
    int v;
    v = a & 63;
    if (a < 'hF00) return mm[a];
    if (a == 'hF3E) return (p >> 6) & 63;
    if (a == 'hF3F) return p & 63;
    if ((a >> 6) == 'h3E) return ((v << 1) | (v >> 5)) & 63;
    if ((a >> 6) == 'h3F) return ((v >> 1) | ((v & 1) << 5)) & 63;
    return 0;
  endfunction

  function automatic int rsel(input int s);
    if (s == 0) return m_a;
    if (s == 1) return m_b;
    return m_c;
  endfunction

  function automatic string ltag(input int a);
    if (a < 'hF00) return "R14";
    if (a == 'hF3E || a == 'hF3F) return "R9";
    if ((a >> 6) >= 'h3E) return "R10";
    return "R11";
  endfunction

  task automatic push(input int a, input int w, input int iq, input string tg);
    qa.push_back(a);
    qw.push_back(w);
    qd.push_back(m_c);
    qi.push_back(iq);
    qt.push_back(tg);
  endtask

  // instruction-level reference, expanded into one expected entry per clock
  task automatic run_model();
    int p, w, op, y, z, yv, zv, ea, iq, halts, res;
    string tg;
    halts = 0;
    for (int n = 0; n < 400; n++) begin
      p  = m_pc;
      w  = rd(p, p);
      op = w >> 4; y = (w >> 2) & 3; z = w & 3;
      iq = (p < 3) ? 1 : 0;
      tg = iq ? "R13" : "R2";
      push(p, 0, iq, tg);
      m_pc = p + 1;
      push(m_pc, 0, iq, tg);
      yv = rsel(y); zv = rsel(z);
      if (!(op == 0 && y == 3)) begin
        if (y == 3) begin yv = rd(m_pc, m_pc); m_pc++; push(m_pc, 0, iq, tg); end
        if (z == 3) begin zv = rd(m_pc, m_pc); m_pc++; push(m_pc, 0, iq, tg); end
      end
      ea = yv * 64 + zv;
      case (op)
        0: begin
          if (y == 3) begin
            if (z == 3) begin
              push(m_pc, 0, 0, "R12");
              halts++;
              if (halts == 1) begin
                repeat (6) push(m_pc, 0, 0, "R12");
                push(m_pc, 0, 1, "R12");
              end else begin
                repeat (5) push(m_pc, 0, 0, "R12");
                return;
              end
            end else push(m_pc, 0, iq, "R5");
          end else begin
            push(m_pc, 0, iq, iq ? "R13" : "R4");
            res = 63 & ~(yv | zv);
            if (y == 0) m_a = res; else if (y == 1) m_b = res; else m_c = res;
          end
        end
        1: begin
          push(m_pc, 0, iq, (y == 3 && z == 3) ? "R6" : "R3");
          m_pc = ea;
        end
        2: begin
          push(ea, 0, iq, ltag(ea));
          push(m_pc, 0, iq, ltag(ea));
          m_c = rd(ea, m_pc);
        end
        default: begin
          push(ea, (ea < 'hF00) ? 1 : 0, iq, (ea < 'hF00) ? "R7" : "R8");
          if (ea < 'hF00) mm[ea] = m_c;
        end
      endcase
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mm[i] = 0;
      ram[i] <= 6'd0;
    end
    put('h110, 'h2D);
    e(ins(0,0,0));                       // NOR A,A -> 3F (irq high, R13)
    e(ins(0,1,3)); e('h15);              // NOR B,#15 -> 2A
    e(ins(0,2,0));                       // NOR C,A -> 00
    e(ins(0,2,1));                       // NOR C,B -> 15 (R4)
    e(ins(3,3,3)); e('h04); e('h00);     // STORE 100 (R7)
    e(ins(3,3,3)); e('h3E); e('h00);     // STORE F80 ignored (R8)
    e(ins(3,3,3)); e('h3C); e('h3E);     // STORE F3E ignored (R8)
    e(ins(3,0,1));                       // STORE {A,B}=FEA ignored (R8)
    e(ins(3,1,2));                       // STORE {B,C}=A95 (R3)
    e(ins(2,3,3)); e('h3E); e('h05);     // LOAD F85 -> 0A (R10)
    e(ins(3,3,3)); e('h04); e('h01);
    e(ins(2,3,3)); e('h3F); e('h05);     // LOAD FC5 -> 22 (R10)
    e(ins(2,3,3)); e('h3F); e('h01);     // LOAD FC1 -> 20 (R10)
    e(ins(2,3,3)); e('h3C); e('h3E);     // PC high (R9)
    e(ins(2,3,3)); e('h3C); e('h3F);     // PC low (R9)
    e(ins(3,3,3)); e('h04); e('h02);
    e(ins(2,3,3)); e('h3C); e('h00);     // reserved (R11)
    e(ins(2,3,3)); e('h3D); e('h00);     // reserved (R11)
    e(ins(2,3,3)); e('h04); e('h00);     // LOAD 100 (R14)
    e('h0C); e('h0D); e('h0E);           // no-ops (R5)
    e(ins(1,3,3)); e('h08); e('h00);     // JMP 200 (R6)
    lp = 'h200;
    e(ins(0,0,0));
    e(ins(0,0,3)); e('h37);
    e(ins(0,1,1));
    e(ins(0,1,3)); e('h3F);
    e(ins(0,1,3)); e('h2F);
    e(ins(1,0,1));                       // JMP {A,B} = 210 (R3)
    lp = 'h210;
    e(ins(2,3,1)); e('h04);              // LOAD {#04,B}=110 (R14)
    e('h0F);                             // HLT, wakes on irq (R12)
    e(ins(3,3,3)); e('h04); e('h03);
    e(ins(2,3,3)); e('h3C); e('h3E);     // PC high after jump (R9)
    e(ins(3,3,3)); e('h04); e('h04);
    e('h0F);
    run_model();

    repeat (3) @(negedge clk);
    #1;
    chk(mem_addr == 12'h000, "R1", "reset mem_addr", int'(mem_addr), 0);
    chk(mem_we == 1'b0,      "R1", "reset mem_we", int'(mem_we), 0);
    chk(mem_wdata == 6'd0,   "R1", "reset mem_wdata", int'(mem_wdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    while (qa.size() > 0) begin
      int ea_, ew_, ed_;
      string tg_;
      ea_ = qa.pop_front(); ew_ = qw.pop_front(); ed_ = qd.pop_front();
      irq = qi.pop_front() != 0;
      tg_ = qt.pop_front();
      #1;
      chk(int'(mem_addr) == ea_,  tg_, "mem_addr", int'(mem_addr), ea_);
      chk(int'(mem_we) == ew_,    tg_, "mem_we", int'(mem_we), ew_);
      chk(int'(mem_wdata) == ed_, tg_, "mem_wdata", int'(mem_wdata), ed_);
      @(negedge clk);
    end
    irq = 1'b0;
    chk(ram['h100] == 6'h15, "R7", "ram[100]", int'(ram['h100]), 'h15);
    chk(ram['hA95] == 6'h15, "R7", "ram[A95]", int'(ram['hA95]), 'h15);
    chk(ram['h101] == 6'h0A, "R10", "ram[101]", int'(ram['h101]), 'h0A);
    chk(ram['h102] == 6'h22, "R9", "ram[102]", int'(ram['h102]), 'h22);
    chk(ram['h103] == 6'h2D, "R14", "ram[103]", int'(ram['h103]), 'h2D);
    chk(ram['h104] == 6'h08, "R9", "ram[104]", int'(ram['h104]), 'h08);
    chk(ram['hF80] == 6'h00, "R8", "ram[F80]", int'(ram['hF80]), 0);
    chk(ram['hF3E] == 6'h00, "R8", "ram[F3E]", int'(ram['hF3E]), 0);
    chk(ram['hFEA] == 6'h00, "R8", "ram[FEA]", int'(ram['hFEA]), 0);
    for (int i = 0; i < 'hF00; i++)
      if (int'(ram[i]) != mm[i])
        chk(0, "R7", $sformatf("ram[%0h]", i), int'(ram[i]), mm[i]);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule